// File: doc/BRIEF.md
# Serial DAC Start-up and Update Sequencer

This block is a write-only serial master for a two-channel voltage DAC on a three-wire link: an active-low select, a serial clock and a data line toward the converter. The converter has no return data line, so the block never reads and never waits for a reply.

After reset the block sends a fixed power-up script without help from the user. The script first switches the converter to an external reference. It then sets the reference halving and a gain of two on both outputs. Last, it loads a mid-scale code into channel A and a full-scale code into channel B.

Once the script has finished, the block accepts channel-code updates on a valid/ready port. Each accepted update becomes exactly one 24-bit write frame. The serial clock rate, the select-to-clock setup time, the clock-to-select hold time and the minimum select-high gap are all set by parameters counted in system clocks.

Top module: `dacseq_top`

## Requirements
- R1: While reset is held, and in the first cycle after it, `spiCsN` is 1, `spiSclk` is 0, `updReady` is 0 and `frameDone` is 0.
- R2: The serial clock idles low and stays low whenever `spiCsN` is high. `spiMosi` changes only on a rising serial-clock edge (or while select is high) and holds steady while `spiSclk` is high, so the converter can capture on the falling edge.
- R3: Each frame has exactly 24 serial-clock pulses, all inside one low period of `spiCsN`. Bits go out most significant first, and select goes high between frames.
- R4: Frame bit 23 is the read/write flag and is always 0. Bits 22:16 hold a 7-bit register address and bits 15:0 hold a 16-bit data word.
- R5: After reset, the first four frames are, in this order: address 0x03 with data 0x0100, address 0x04 with data 0x0103, address 0x08 with data 0x7FFF, and address 0x09 with data 0xFFFF.
- R6: An update accepted with `updChan`=0 sends one frame to address 0x08, and one accepted with `updChan`=1 sends one frame to address 0x09. In both cases the data is `updCode` as sampled at acceptance, and frames go out in the order they were accepted.
- R7: `updReady` stays 0 until all four script frames have completed, and it is 0 while any frame is in progress (select low).
- R8: The first rising serial-clock edge comes exactly SETUP_CYC system clocks after `spiCsN` falls. `spiCsN` rises exactly HOLD_CYC system clocks after the 24th falling edge.
- R9: Between two frames, `spiCsN` stays high for at least the larger of GAP_CYC and 2*DIV_HALF system clocks.
- R10: `frameDone` is a one-cycle pulse issued once per completed frame, while `spiCsN` is high.
- R11: Each high and each low half of the serial clock inside a frame lasts exactly DIV_HALF system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| updValid | input | 1 | Update request valid |
| updChan | input | 1 | Target channel: 0 = A, 1 = B |
| updCode | input | 16 | Channel code to write |
| updReady | output | 1 | Update can be accepted this cycle |
| spiCsN | output | 1 | Active-low frame select |
| spiSclk | output | 1 | Serial clock (idles low) |
| spiMosi | output | 1 | Serial data toward the converter |
| frameDone | output | 1 | One-cycle pulse after each frame |

## Verification
Two events can land in the same cycle:
- the completion of the last script frame, with its `frameDone` pulse and the first rise of `updReady`;
- a user request that has been waiting since reset.

The bench raises `updValid` in the first cycle after reset, before the script has started. The test is judged by three things: the frame order seen on the wire, where the request must become the fifth frame and nothing earlier; `updReady` never being high during the script or while select is low; and exactly one done pulse per frame. Back-to-back requests, with `updValid` raised again right after a frame ends, also put a new acceptance in the cycle right after a done pulse. These are checked the same way through frame order and pulse count.

// File: rtl/dacseq_pkg.sv
package dacseq_pkg;

  localparam int ADDR_W     = 7;
  localparam int DATA_W     = 16;
  localparam int FRAME_W    = 1 + ADDR_W + DATA_W;
  localparam int SCRIPT_LEN = 4;
  localparam int SEQ_W      = $clog2(SCRIPT_LEN);

  localparam logic [ADDR_W-1:0] ADDR_REFCFG = 7'h03;
  localparam logic [ADDR_W-1:0] ADDR_GAIN   = 7'h04;
  localparam logic [ADDR_W-1:0] ADDR_CHA    = 7'h08;
  localparam logic [ADDR_W-1:0] ADDR_CHB    = 7'h09;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_SHIFT, ST_HOLD, ST_GAP
  } state_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic             load;
    logic             fromScript;
    logic [SEQ_W-1:0] seqIdx;
    logic             shift;
    logic             sclkSet;
    logic             sclkClr;
    logic             csLow;
    logic             csHigh;
  } strobe_t;

  // R4: write flag low, address, then data
  function automatic logic [FRAME_W-1:0] packFrame(
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] data
  );
    return {1'b0, addr, data};
  endfunction

  // R5: power-up script, order is behaviour
  function automatic logic [FRAME_W-1:0] scriptFrame(input logic [SEQ_W-1:0] idx);
    case (idx)
      2'd0:    return packFrame(ADDR_REFCFG, 16'h0100);
      2'd1:    return packFrame(ADDR_GAIN,   16'h0103);
      2'd2:    return packFrame(ADDR_CHA,    16'h7FFF);
      default: return packFrame(ADDR_CHB,    16'hFFFF);
    endcase
  endfunction

endpackage

// File: rtl/dacseq_ctrl.sv
module dacseq_ctrl
  import dacseq_pkg::*;
#(
  parameter int DIV_HALF  = 2,
  parameter int SETUP_CYC = 3,
  parameter int HOLD_CYC  = 2,
  parameter int GAP_CYC   = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    updValid,
  output logic    updReady,
  output strobe_t strb,
  output logic    frameDone
);

  localparam int GAP_EFF = (GAP_CYC > 2 * DIV_HALF) ? GAP_CYC : 2 * DIV_HALF;
  localparam int MAX_A   = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
  localparam int MAX_B   = (DIV_HALF > GAP_EFF) ? DIV_HALF : GAP_EFF;
  localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_C + 1);
  localparam int BIT_W   = $clog2(FRAME_W);

  localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] HALF_LAST  = CNT_W'(DIV_HALF - 1);
  localparam logic [CNT_W-1:0] GAP_LAST   = CNT_W'(GAP_EFF - 1);
  localparam logic [BIT_W-1:0] BIT_LAST   = BIT_W'(FRAME_W - 1);
  localparam logic [SEQ_W-1:0] SEQ_LAST   = SEQ_W'(SCRIPT_LEN - 1);

  state_t           state, stateN;
  logic [CNT_W-1:0] cnt, cntN;
  logic [BIT_W-1:0] bitCnt, bitN;
  logic             phaseHi, phaseN;
  logic [SEQ_W-1:0] seqIdx, seqN;
  logic             scriptDone, doneN;
  logic             pulseN;

  always_comb begin
    strb            = '0;
    strb.seqIdx     = seqIdx;
    strb.fromScript = !scriptDone;
    stateN          = state;
    cntN            = cnt;
    bitN            = bitCnt;
    phaseN          = phaseHi;
    seqN            = seqIdx;
    doneN           = scriptDone;
    pulseN          = 1'b0;
    updReady        = (state == ST_IDLE) && scriptDone;
    case (state)
      ST_IDLE: begin
        if (!scriptDone || updValid) begin
          strb.load  = 1'b1;
          strb.csLow = 1'b1;
          stateN     = ST_SETUP;
          cntN       = '0;
        end
      end
      ST_SETUP: begin
        if (cnt == SETUP_LAST) begin
          strb.sclkSet = 1'b1;
          stateN       = ST_SHIFT;
          cntN         = '0;
          bitN         = '0;
          phaseN       = 1'b1;
        end else begin
          cntN = cnt + 1'b1;
        end
      end
      ST_SHIFT: begin
        if (cnt == HALF_LAST) begin
          cntN = '0;
          if (phaseHi) begin
            strb.sclkClr = 1'b1;
            phaseN       = 1'b0;
            if (bitCnt == BIT_LAST) stateN = ST_HOLD;
            else                    bitN   = bitCnt + 1'b1;
          end else begin
            strb.sclkSet = 1'b1;
            strb.shift   = 1'b1;
            phaseN       = 1'b1;
          end
        end else begin
          cntN = cnt + 1'b1;
        end
      end
      ST_HOLD: begin
        if (cnt == HOLD_LAST) begin
          strb.csHigh = 1'b1;
          stateN      = ST_GAP;
          cntN        = '0;
        end else begin
          cntN = cnt + 1'b1;
        end
      end
      ST_GAP: begin
        if (cnt == GAP_LAST) begin
          stateN = ST_IDLE;
          pulseN = 1'b1;
          cntN   = '0;
          if (!scriptDone) begin
            if (seqIdx == SEQ_LAST) doneN = 1'b1;
            else                    seqN  = seqIdx + 1'b1;
          end
        end else begin
          cntN = cnt + 1'b1;
        end
      end
      default: stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      bitCnt     <= '0;
      phaseHi    <= 1'b0;
      seqIdx     <= '0;
      scriptDone <= 1'b0;
      frameDone  <= 1'b0;
    end else begin
      state      <= stateN;
      cnt        <= cntN;
      bitCnt     <= bitN;
      phaseHi    <= phaseN;
      seqIdx     <= seqN;
      scriptDone <= doneN;
      frameDone  <= pulseN;
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

  // R7
  ready_script_chk: assert property (@(posedge clk) disable iff (!rstN)
    updReady |-> !strb.shift && !strb.sclkSet);

endmodule

// File: rtl/dacseq_datapath.sv
module dacseq_datapath
  import dacseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              updChan,
  input  logic [DATA_W-1:0] updCode,
  output logic              spiCsN,
  output logic              spiSclk,
  output logic              spiMosi
);

  localparam int RC_W = $clog2(FRAME_W) + 1;
  localparam logic [RC_W-1:0] FRAME_EDGES = RC_W'(FRAME_W);

  logic [FRAME_W-1:0] shReg;
  logic [FRAME_W-1:0] frameIn;
  logic               csReg, sclkReg;
  logic [RC_W-1:0]    riseCnt;

  // R6: user frame addressing by channel
  always_comb begin
    if (strb.fromScript) frameIn = scriptFrame(strb.seqIdx);
    else                 frameIn = packFrame(updChan ? ADDR_CHB : ADDR_CHA, updCode);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg   <= '0;
      csReg   <= 1'b1;
      sclkReg <= 1'b0;
    end else begin
      if (strb.load)       shReg <= frameIn;
      else if (strb.shift) shReg <= {shReg[FRAME_W-2:0], 1'b0};
      if (strb.csLow)       csReg <= 1'b0;
      else if (strb.csHigh) csReg <= 1'b1;
      if (strb.sclkSet)      sclkReg <= 1'b1;
      else if (strb.sclkClr) sclkReg <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             riseCnt <= '0;
    else if (strb.csLow)   riseCnt <= '0;
    else if (strb.sclkSet) riseCnt <= riseCnt + 1'b1;
  end

  assign spiCsN  = csReg;
  assign spiSclk = sclkReg;
  assign spiMosi = shReg[FRAME_W-1];

  // R3
  frame_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csReg) |-> riseCnt == FRAME_EDGES);

  // R2
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    csReg |-> !sclkReg);

  // R2
  mosi_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    sclkReg && $past(sclkReg) |-> $stable(shReg[FRAME_W-1]));

  // R4
  rw_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csReg) |-> !shReg[FRAME_W-1]);

endmodule

// File: rtl/dacseq_top.sv
module dacseq_top
  import dacseq_pkg::*;
#(
  parameter int DIV_HALF  = 2,
  parameter int SETUP_CYC = 3,
  parameter int HOLD_CYC  = 2,
  parameter int GAP_CYC   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              updValid,
  input  logic              updChan,
  input  logic [DATA_W-1:0] updCode,
  output logic              updReady,
  output logic              spiCsN,
  output logic              spiSclk,
  output logic              spiMosi,
  output logic              frameDone
);

  strobe_t strb;

  dacseq_ctrl #(
    .DIV_HALF (DIV_HALF),
    .SETUP_CYC(SETUP_CYC),
    .HOLD_CYC (HOLD_CYC),
    .GAP_CYC  (GAP_CYC)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .updValid (updValid),
    .updReady (updReady),
    .strb     (strb),
    .frameDone(frameDone)
  );

  dacseq_datapath uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .updChan(updChan),
    .updCode(updCode),
    .spiCsN (spiCsN),
    .spiSclk(spiSclk),
    .spiMosi(spiMosi)
  );

  // R7
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    updReady |-> spiCsN && !spiSclk);

endmodule

// File: tb/sim_dacseq_top.sv
`timescale 1ns/1ps
module sim_dacseq_top;

  localparam int DIV_HALF  = 2;
  localparam int SETUP_CYC = 3;
  localparam int HOLD_CYC  = 2;
  localparam int GAP_CYC   = 3;
  localparam int GAP_EFF   = (GAP_CYC > 2 * DIV_HALF) ? GAP_CYC : 2 * DIV_HALF;
  localparam int N_RAND    = 20;

  logic        clk = 1'b0;
  logic        rstN;
  logic        updValid;
  logic        updChan;
  logic [15:0] updCode;
  logic        updReady, spiCsN, spiSclk, spiMosi, frameDone;

  int checks = 0;
  int errors = 0;
  int nUser  = 0;
  logic [23:0] expQ[$];

  always #2.5 clk = ~clk;

  dacseq_top #(
    .DIV_HALF (DIV_HALF),
    .SETUP_CYC(SETUP_CYC),
    .HOLD_CYC (HOLD_CYC),
    .GAP_CYC  (GAP_CYC)
  ) u0 (
    .clk      (clk),
    .rstN     (rstN),
    .updValid (updValid),
    .updChan  (updChan),
    .updCode  (updCode),
    .updReady (updReady),
    .spiCsN   (spiCsN),
    .spiSclk  (spiSclk),
    .spiMosi  (spiMosi),
    .frameDone(frameDone)
  );

  function automatic logic [23:0] expFrame(input logic ch, input logic [15:0] code);
    return {1'b0, (ch ? 7'h09 : 7'h08), code};
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Wire monitor, sampled at the falling system-clock edge
  logic        prevCs = 1'b1, prevSclk = 1'b0, prevMosi = 1'b0, prevDone = 1'b0;
  int          setupCnt = 0, holdCnt = 0, gapCnt = 0, halfCnt = 0, bitsSeen = 0;
  int          framesSeen = 0, donePulses = 0;
  int          readyErr = 0, mosiErr = 0, modeErr = 0, doneErr = 0;
  bit          firstFrame = 1'b1, firstRise = 1'b0;
  logic [23:0] rx = '0;

  always @(negedge clk) begin
    if (rstN) begin
      setupCnt++; holdCnt++; gapCnt++; halfCnt++;
      if (prevCs && !spiCsN) begin
        if (!firstFrame) check(gapCnt >= GAP_EFF, "R9 gap", gapCnt, GAP_EFF);
        setupCnt = 0; bitsSeen = 0; rx = '0; firstRise = 1'b0;
      end
      if (!prevSclk && spiSclk) begin
        if (!firstRise) begin
          check(setupCnt == SETUP_CYC, "R8 setup", setupCnt, SETUP_CYC);
          firstRise = 1'b1;
        end else begin
          check(halfCnt == DIV_HALF, "R11 low half", halfCnt, DIV_HALF);
        end
        check(!spiCsN, "R3 edge inside select", spiCsN, 0);
        halfCnt = 0;
      end
      if (prevSclk && !spiSclk) begin
        check(halfCnt == DIV_HALF, "R11 high half", halfCnt, DIV_HALF);
        rx = {rx[22:0], spiMosi};
        bitsSeen++;
        holdCnt = 0; halfCnt = 0;
      end
      if (prevSclk && spiSclk && spiMosi != prevMosi) mosiErr++;
      if (spiCsN && spiSclk) modeErr++;
      if (!prevCs && spiCsN) begin
        check(bitsSeen == 24, "R3 bits", bitsSeen, 24);
        check(holdCnt == HOLD_CYC, "R8 hold", holdCnt, HOLD_CYC);
        check(rx[23] == 1'b0, "R4 rw flag", rx[23], 0);
        if (expQ.size() == 0) begin
          check(1'b0, "R6 unexpected frame", rx, 0);
        end else begin
          logic [23:0] e;
          e = expQ.pop_front();
          check(rx == e, (framesSeen < 4) ? "R5 script frame" : "R6 user frame", rx, e);
        end
        framesSeen++;
        gapCnt = 0; firstFrame = 1'b0;
      end
      if (frameDone) begin
        donePulses++;
        if (prevDone || !spiCsN) doneErr++;
      end
      if (updReady && (!spiCsN || framesSeen < 4)) readyErr++;
    end
    prevCs = spiCsN; prevSclk = spiSclk; prevMosi = spiMosi; prevDone = frameDone;
  end

  task automatic sendUpd(input logic ch, input logic [15:0] code);
    updChan  = ch;
    updCode  = code;
    updValid = 1'b1;
    while (!updReady) @(negedge clk);
    expQ.push_back(expFrame(ch, code));
    nUser++;
    @(negedge clk);
    updValid = 1'b0;
    updCode  = $urandom;
    updChan  = 1'($urandom);
  endtask

  task automatic finishRun();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; updValid = 1'b0; updChan = 1'b0; updCode = '0;
    repeat (5) @(negedge clk);
    // R1: state during reset
    check(spiCsN == 1'b1, "R1 csN", spiCsN, 1);
    check(spiSclk == 1'b0, "R1 sclk", spiSclk, 0);
    check(updReady == 1'b0, "R1 ready", updReady, 0);
    check(frameDone == 1'b0, "R1 done", frameDone, 0);
    expQ.push_back(24'h030100);
    expQ.push_back(24'h040103);
    expQ.push_back(24'h087FFF);
    expQ.push_back(24'h09FFFF);
    rstN = 1'b1;
    @(negedge clk);
    // R1: first cycle after reset
    check(updReady == 1'b0, "R1 ready after reset", updReady, 0);
    check(frameDone == 1'b0, "R1 done after reset", frameDone, 0);
    // R7: request pending during the script
    sendUpd(1'b0, 16'h1234);
    // R6 corner codes, back to back
    sendUpd(1'b1, 16'h0000);
    sendUpd(1'b0, 16'hFFFF);
    sendUpd(1'b1, 16'h8000);
    sendUpd(1'b0, 16'h0001);
    for (int i = 0; i < N_RAND; i++) begin
      repeat ($urandom_range(0, 5)) @(negedge clk);
      sendUpd(1'($urandom), 16'($urandom));
    end
    while (expQ.size() != 0 || !spiCsN) @(negedge clk);
    repeat (20) @(negedge clk);
    check(framesSeen == 4 + nUser, "R6 frame count", framesSeen, 4 + nUser);
    check(donePulses == framesSeen, "R10 done pulses", donePulses, framesSeen);
    check(doneErr == 0, "R10 done shape", doneErr, 0);
    check(readyErr == 0, "R7 ready misuse", readyErr, 0);
    check(mosiErr == 0, "R2 data stable while high", mosiErr, 0);
    check(modeErr == 0, "R2 clock idle low", modeErr, 0);
    finishRun();
  end

endmodule